// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block is the bit-level core of a serial port. Its transmit half takes one byte at a time from an upstream queue and shifts it onto a single output line as a framed character. The frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. Its receive half watches the input line with a sixteen-times oversample tick. It finds start bits, samples each bit at its centre, and hands every received character downstream with a parity-error flag, a framing-error flag and a break flag.

The frame shape comes from static configuration inputs: a two-bit length code, a parity enable, a parity sense, a two-bit stop code and a flow-control mode bit. Bit timing comes from two strobes made by an external rate generator. One is a tick once per bit period for the transmitter. The other is a tick sixteen times per bit period for the receiver. In four-wire mode a clear-to-send input gates the start of each outgoing frame. A request-to-send output tells the remote end whether the local receive queue can take more data. In two-wire mode both flow-control pins are disregarded.

Top module: `async_frame_engine`

## Requirements
- R1: The length code `cfg_len` selects the number of data bits as 8 minus the code (00→8, 01→7, 10→6, 11→5). The transmitter sends a low start bit and then those data bits, bit 0 first. The receiver returns them right-aligned in `rx_data`, with the unused upper bits zero.
- R2: When `cfg_par_en` is 1, a parity bit follows the last data bit. With `cfg_par_odd`=0 it makes the count of ones over the data and parity bits even. With `cfg_par_odd`=1 it makes that count odd.
- R3: `cfg_stop`=01 selects two high stop bits. Every other code selects one stop bit.
- R4: `tx_busy` is high from the first cycle of the start bit until the bit tick that ends the last stop bit. While `tx_busy` is low, `txd` is high.
- R5: A frame starts only in a cycle where `bit_tick` and `tx_valid` are both high. `tx_ready` is high in exactly that cycle, which marks `tx_data` as taken.
- R6: With `cfg_two_wire`=0, a frame starts only while the synchronized `cts` is high. With `cfg_two_wire`=1, `cts` has no effect.
- R7: `rts` is low in reset. After reset it is registered: with `cfg_two_wire`=1 it is held high, and otherwise it equals the inverse of `rx_full`.
- R8: The receiver samples the start bit at mid-bit. If the line is high there, the start is dropped and no character is reported.
- R9: `rx_par_err` is set when parity is enabled and the received parity bit does not match the configured sense.
- R10: `rx_frm_err` is set when any configured stop bit is sampled low.
- R11: `rx_brk` is set when a character has a framing error and all of its data bits are zero.
- R12: Each received character raises `rx_valid` for exactly one cycle, with data and flags valid in that cycle. All flags are low when `rx_valid` is low.
- R13: After each character the receiver waits for the line to go high before it looks for a new start bit, so a line held low reports a single break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe per transmit bit period |
| os_tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| cfg_len | input | 2 | Data length code (8 minus code) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop | input | 2 | 01 = two stop bits, else one |
| cfg_two_wire | input | 1 | 1 = ignore flow-control pins |
| tx_valid | input | 1 | A byte is waiting to be sent |
| tx_data | input | 8 | Byte to be sent |
| tx_ready | output | 1 | Byte taken this cycle |
| tx_busy | output | 1 | Frame in progress on the line |
| txd | output | 1 | Serial output line, idle high |
| cts | input | 1 | Remote end allows sending (asynchronous) |
| rts | output | 1 | Local end can accept data |
| rx_full | input | 1 | Downstream receive queue is full |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received data, right-aligned |
| rx_par_err | output | 1 | Parity mismatch on this character |
| rx_frm_err | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Framing error on all-zero data |

## Verification
The bench loops the transmitter back into the receiver. It sweeps every combination of length, parity and stop code over patterns that set the top and bottom data bits. A transmitter that ignored a length code, ordered bits wrongly, or miscomputed the odd/even sense would show a wrong bit at a given mid-bit sample or a spurious parity flag. Hand-built input frames then go after the receive corners: a corrupted parity bit, a low stop bit on nonzero data (framing but no break), the same on zero data (break), a bad second stop bit, and a short low glitch that a receiver without the mid-bit check would turn into a phantom character. A long low line checks that a receiver which rehunts at once would report a string of breaks instead of one. Flow control is tested by holding clear-to-send low in four-wire mode, where any start is an error, and by checking that request-to-send follows the full flag only outside two-wire mode.

// File: rtl/afe_pkg.sv
// Shared types and helpers for the asynchronous frame engine.
// Assumes the data length code counts down from eight bits.
package afe_pkg;

    localparam int DATA_MAX  = 8;
    localparam int FRAME_MAX = DATA_MAX + 4;          // start + data + parity + two stops
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam int IDX_W     = $clog2(DATA_MAX);

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } afe_cfg_t;

    typedef enum logic [2:0] {
        RX_WAITH,
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    // Number of data bits selected by the length code.
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd8 - {2'b00, code};
    endfunction

endpackage

// File: rtl/afe_sync.sv
// Multi-flop synchronizer for one asynchronous input.
// Assumes STAGES >= 1; RST_VAL is the value seen while in reset.
module afe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop capture.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= RST_VAL;
                else        pipe <= d;
            end
        end else begin : g_chain
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= {STAGES{RST_VAL}};
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/afe_tx.sv
// Transmit serializer. Builds a whole frame in one step when a byte is taken,
// then shifts one bit out per bit tick. The next frame may load on the tick
// that ends the last stop bit, so frames can run back to back.
// Assumes bit_tick is a single-cycle strobe.
module afe_tx
    import afe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  afe_cfg_t            cfg,
    input  logic                cts_ok,
    input  logic                tx_valid,
    input  logic [DATA_MAX-1:0] tx_data,
    output logic                tx_ready,
    output logic                tx_busy,
    output logic                txd
);
    logic [FRAME_MAX-1:0] frame_vec;
    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     left;
    logic [CNT_W-1:0]     total;
    logic [3:0]           nbits;
    logic                 par_bit;
    logic                 line_q;
    logic                 can_load;

    // Assemble the frame image, bit 0 first on the line.
    always_comb begin
        nbits   = data_bits(cfg.len);
        par_bit = cfg.par_odd;
        frame_vec = '1;
        frame_vec[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(nbits)) begin
                frame_vec[1 + i] = tx_data[i];
                par_bit = par_bit ^ tx_data[i];
            end
        end
        if (cfg.par_en) frame_vec[nbits + 4'd1] = par_bit;
        total = CNT_W'(nbits) + CNT_W'(2) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
    end

    assign can_load = (left == '0) || (left == CNT_W'(1));
    assign tx_ready = bit_tick && can_load && tx_valid && cts_ok;

    // Load a new frame or advance the current one on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left   <= '0;
            shreg  <= '1;
            line_q <= 1'b1;
        end else if (tx_ready) begin
            line_q <= frame_vec[0];
            shreg  <= {1'b1, frame_vec[FRAME_MAX-1:1]};
            left   <= total;
        end else if (bit_tick && left != '0) begin
            line_q <= (left == CNT_W'(1)) ? 1'b1 : shreg[0];
            shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
            left   <= left - CNT_W'(1);
        end
    end

    assign tx_busy = (left != '0);
    assign txd     = line_q;
endmodule

// File: rtl/afe_rx.sv
// Receive deserializer on the oversample tick. Confirms a start bit at mid-bit,
// samples data, parity and stop bits at their centres, and reports one
// character with its error flags. Waits for a high line between characters.
// Assumes rxd is already synchronized and os_tick runs at OS_RATE per bit.
module afe_rx
    import afe_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  afe_cfg_t            cfg,
    input  logic                rxd,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_par_err,
    output logic                rx_frm_err,
    output logic                rx_brk
);
    localparam int OS_W = $clog2(OS_RATE);
    localparam logic [OS_W-1:0] HALF = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0] FULL = OS_W'(OS_RATE - 1);

    rx_state_e           state;
    logic [OS_W-1:0]     os_cnt;
    logic [IDX_W-1:0]    bit_idx;
    logic [DATA_MAX-1:0] data_q;
    logic                par_acc;
    logic                stop_bad;
    logic                last_data;
    logic                last_stop;
    logic                frm_now;

    assign last_data = ({1'b0, bit_idx} == data_bits(cfg.len) - 4'd1);
    assign last_stop = (bit_idx == IDX_W'(cfg.two_stop));
    assign frm_now   = stop_bad | ~rxd;

    // Frame state machine; output strobe and flags default to zero each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_WAITH;
            os_cnt     <= '0;
            bit_idx    <= '0;
            data_q     <= '0;
            par_acc    <= 1'b0;
            stop_bad   <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
            rx_brk     <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
            rx_brk     <= 1'b0;
            if (os_tick) begin
                case (state)
                    RX_WAITH: if (rxd) state <= RX_IDLE;
                    RX_IDLE: if (!rxd) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                    RX_START: if (os_cnt == HALF) begin
                        os_cnt <= '0;
                        if (rxd) begin
                            state <= RX_IDLE;
                        end else begin
                            state    <= RX_DATA;
                            bit_idx  <= '0;
                            data_q   <= '0;
                            par_acc  <= cfg.par_odd;
                            stop_bad <= 1'b0;
                        end
                    end else begin
                        os_cnt <= os_cnt + OS_W'(1);
                    end
                    RX_DATA: if (os_cnt == FULL) begin
                        os_cnt          <= '0;
                        data_q[bit_idx] <= rxd;
                        par_acc         <= par_acc ^ rxd;
                        if (last_data) begin
                            bit_idx <= '0;
                            state   <= cfg.par_en ? RX_PAR : RX_STOP;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                        end
                    end else begin
                        os_cnt <= os_cnt + OS_W'(1);
                    end
                    RX_PAR: if (os_cnt == FULL) begin
                        os_cnt  <= '0;
                        par_acc <= par_acc ^ rxd;
                        state   <= RX_STOP;
                    end else begin
                        os_cnt <= os_cnt + OS_W'(1);
                    end
                    RX_STOP: if (os_cnt == FULL) begin
                        os_cnt <= '0;
                        if (last_stop) begin
                            state      <= RX_WAITH;
                            rx_valid   <= 1'b1;
                            rx_data    <= data_q;
                            rx_par_err <= cfg.par_en & par_acc;
                            rx_frm_err <= frm_now;
                            rx_brk     <= frm_now && (data_q == '0);
                        end else begin
                            stop_bad <= frm_now;
                            bit_idx  <= bit_idx + IDX_W'(1);
                        end
                    end else begin
                        os_cnt <= os_cnt + OS_W'(1);
                    end
                    default: state <= RX_WAITH;
                endcase
            end
        end
    end
endmodule

// File: rtl/async_frame_engine.sv
// Top of the asynchronous frame engine: synchronizes the asynchronous pins,
// applies flow control and joins the transmit and receive halves.
// Assumes bit_tick and os_tick come from one rate generator in clk's domain.
module async_frame_engine
    import afe_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       os_tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_stop,
    input  logic       cfg_two_wire,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_busy,
    output logic       txd,
    input  logic       cts,
    output logic       rts,
    input  logic       rx_full,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_par_err,
    output logic       rx_frm_err,
    output logic       rx_brk
);
    afe_cfg_t cfg;
    logic     rxd_sync;
    logic     cts_sync;
    logic     cts_ok;
    logic     rts_q;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                   two_stop: (cfg_stop == 2'b01)};

    afe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_sync)
    );

    afe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .d(cts), .q(cts_sync)
    );

    assign cts_ok = cfg_two_wire | cts_sync;

    // Request-to-send: held high in two-wire mode, else follows queue space.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_q <= 1'b0;
        else        rts_q <= cfg_two_wire | ~rx_full;
    end
    assign rts = rts_q;

    afe_tx u_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg(cfg),
        .cts_ok(cts_ok), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_busy(tx_busy), .txd(txd)
    );

    afe_rx #(.OS_RATE(OS_RATE)) u_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg(cfg), .rxd(rxd_sync),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
    );
endmodule

// File: rtl/afe_checker.sv
// Temporal checks on the frame engine ports, bound into every instance.
// Assumes the configuration inputs stay static while a character is in flight.
module afe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic [1:0] cfg_len,
    input logic       cfg_two_wire,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_busy,
    input logic       txd,
    input logic       cts_sync,
    input logic       rts,
    input logic       rx_full,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_par_err,
    input logic       rx_frm_err,
    input logic       rx_brk
);
    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    p_take_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (bit_tick && tx_valid));

    p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_two_wire && !cts_sync) |-> !tx_ready);

    p_rts_two_wire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_two_wire |=> rts);

    p_rts_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_two_wire && rx_full) |=> !rts);

    p_len_zero_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (4'd8 - {2'b00, cfg_len})) == 8'd0));

    p_brk_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == 8'd0));

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_quiet_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> !(rx_par_err || rx_frm_err || rx_brk));
endmodule

bind async_frame_engine afe_checker u_chk (.*);

// File: tb/sim_async_frame_engine.sv
module sim_async_frame_engine;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick, os_tick;
    logic [1:0] cfg_len;
    logic       cfg_par_en, cfg_par_odd;
    logic [1:0] cfg_stop;
    logic       cfg_two_wire;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready, tx_busy, txd;
    logic       cts, rts, rx_full;
    logic       rxd;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_par_err, rx_frm_err, rx_brk;
    logic       loop_en, rxd_bench;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign rxd = loop_en ? txd : rxd_bench;

    async_frame_engine u0 (.*);

    // Tick generator: 16 oversample ticks and one bit tick per 32 clocks.
    initial begin
        bit_tick = 1'b0;
        os_tick  = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            tcnt     = (tcnt + 1) % 32;
            os_tick  = tcnt[0];
            bit_tick = (tcnt == 31);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] code);
        return 8 - int'(code);
    endfunction

    function automatic int frame_len();
        return 2 + nbits_of(cfg_len) + int'(cfg_par_en) + ((cfg_stop == 2'b01) ? 1 : 0);
    endfunction

    // Expected line bits for one character under the current configuration.
    function automatic logic [11:0] mk_frame(input logic [7:0] d);
        logic [11:0] f;
        int          n;
        logic        p;
        n = nbits_of(cfg_len);
        p = cfg_par_odd;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[1 + i] = d[i];
            p = p ^ d[i];
        end
        if (cfg_par_en) f[1 + n] = p;
        return f;
    endfunction

    // Send one byte, check every line bit at mid-bit and, in loopback, the
    // received character.
    task automatic send_frame(input logic [7:0] d, input bit check_rx, input string req_start);
        logic [11:0] fb;
        int          tot, n, w, seen;
        logic [7:0]  gd, m;
        logic        gpe, gfe, gbk;
        fb  = mk_frame(d);
        tot = frame_len();
        n   = nbits_of(cfg_len);
        m   = 8'hFF >> (8 - n);
        tx_data  = d;
        tx_valid = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!tx_ready && w < 3000);
        chk(tx_ready == 1'b1, req_start, "frame start taken", int'(tx_ready), 1);
        if (!tx_ready) begin
            tx_valid = 1'b0;
            return;
        end
        chk(bit_tick == 1'b1, "R5", "byte taken on bit tick", int'(bit_tick), 1);
        seen = 0; gd = '0; gpe = 0; gfe = 0; gbk = 0;
        fork
            begin
                @(negedge clk);
                tx_valid = 1'b0;
                repeat (15) @(negedge clk);
                for (int k = 0; k < tot; k++) begin
                    if (k == 0)
                        chk(txd == 1'b0, "R1", "start bit", int'(txd), 0);
                    else if (k <= n)
                        chk(txd == fb[k], "R1", $sformatf("data bit %0d of %0h", k - 1, d), int'(txd), int'(fb[k]));
                    else if (cfg_par_en && k == n + 1)
                        chk(txd == fb[k], "R2", $sformatf("parity bit of %0h odd=%0d", d, cfg_par_odd), int'(txd), int'(fb[k]));
                    else
                        chk(txd == 1'b1, "R3", "stop bit", int'(txd), 1);
                    if (k == tot - 1)
                        chk(tx_busy == 1'b1, "R4", "busy in last stop", int'(tx_busy), 1);
                    repeat (32) @(negedge clk);
                end
                chk(tx_busy == 1'b0, "R4", "busy after frame", int'(tx_busy), 0);
                chk(txd == 1'b1, "R4", "idle line high", int'(txd), 1);
            end
            begin
                if (check_rx) begin
                    for (int c = 0; c < 32 * tot + 64; c++) begin
                        @(negedge clk);
                        if (rx_valid) begin
                            seen++;
                            gd = rx_data; gpe = rx_par_err; gfe = rx_frm_err; gbk = rx_brk;
                        end
                    end
                end
            end
        join
        if (check_rx) begin
            chk(seen == 1, "R12", "one character received", seen, 1);
            chk(gd == (d & m), "R1", $sformatf("loopback data len=%0d", n), int'(gd), int'(d & m));
            chk(gpe == 1'b0, "R9", "no parity error on clean frame", int'(gpe), 0);
            chk(gfe == 1'b0, "R10", "no framing error on clean frame", int'(gfe), 0);
            chk(gbk == 1'b0, "R11", "no break on clean frame", int'(gbk), 0);
        end
    endtask

    // Drive a hand-built frame on the receive line and check the report.
    task automatic inject(input logic [11:0] bits, input int tot, input logic [7:0] ed,
                          input logic epe, input logic efe, input logic ebk, input string req);
        int         seen;
        logic [7:0] gd;
        logic       gpe, gfe, gbk;
        seen = 0; gd = '0; gpe = 0; gfe = 0; gbk = 0;
        fork
            begin
                for (int k = 0; k < tot; k++) begin
                    rxd_bench = bits[k];
                    repeat (32) @(negedge clk);
                end
                rxd_bench = 1'b1;
            end
            begin
                for (int c = 0; c < 32 * tot + 80; c++) begin
                    @(negedge clk);
                    if (rx_valid) begin
                        seen++;
                        gd = rx_data; gpe = rx_par_err; gfe = rx_frm_err; gbk = rx_brk;
                    end
                end
            end
        join
        chk(seen == 1, "R12", {req, " report count"}, seen, 1);
        chk(gd == ed, req, "data", int'(gd), int'(ed));
        chk(gpe == epe, "R9", {req, " parity flag"}, int'(gpe), int'(epe));
        chk(gfe == efe, "R10", {req, " framing flag"}, int'(gfe), int'(efe));
        chk(gbk == ebk, "R11", {req, " break flag"}, int'(gbk), int'(ebk));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0]  pats [4] = '{8'h01, 8'h80, 8'hA5, 8'h3C};
        logic [11:0] fb;
        int          cnt;
        bit          bad;
        rst_n = 1'b0;
        cfg_len = 2'b00; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop = 2'b00;
        cfg_two_wire = 1'b1; tx_valid = 0; tx_data = '0;
        cts = 1'b0; rx_full = 1'b0; loop_en = 1'b1; rxd_bench = 1'b1;
        repeat (6) @(negedge clk);
        chk(txd == 1'b1, "R4", "reset line high", int'(txd), 1);
        chk(tx_busy == 1'b0, "R4", "reset not busy", int'(tx_busy), 0);
        chk(rx_valid == 1'b0, "R12", "reset no character", int'(rx_valid), 0);
        chk(rts == 1'b0, "R7", "reset rts low", int'(rts), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(tx_ready == 1'b0, "R5", "no take without valid", int'(tx_ready), 0);

        // Sweep every frame shape in loopback, two-wire mode with cts low (R6).
        for (int ln = 0; ln < 4; ln++)
            for (int pm = 0; pm < 3; pm++)
                for (int st = 0; st < 2; st++) begin
                    cfg_len     = 2'(ln);
                    cfg_par_en  = (pm != 0);
                    cfg_par_odd = (pm == 2);
                    cfg_stop    = st ? 2'b01 : 2'b00;
                    repeat (40) @(negedge clk);
                    for (int p = 0; p < 4; p++)
                        send_frame(pats[p], 1'b1, "R6");
                end

        // Stop code 11 behaves as one stop bit (R3).
        cfg_len = 2'b00; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop = 2'b11;
        repeat (40) @(negedge clk);
        send_frame(8'h96, 1'b1, "R3");

        // Four-wire mode: cts low blocks a start, cts high releases it (R6).
        cfg_stop = 2'b00; cfg_two_wire = 1'b0; cts = 1'b0;
        tx_data = 8'h5A; tx_valid = 1'b1;
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (tx_ready || tx_busy || !txd) bad = 1;
        end
        chk(bad == 0, "R6", "no start while cts low", int'(bad), 0);
        cts = 1'b1;
        send_frame(8'h5A, 1'b1, "R6");

        // Request-to-send follows the full flag only in four-wire mode (R7).
        rx_full = 1'b1;
        repeat (3) @(negedge clk);
        chk(rts == 1'b0, "R7", "rts low when full, four-wire", int'(rts), 0);
        rx_full = 1'b0;
        repeat (3) @(negedge clk);
        chk(rts == 1'b1, "R7", "rts high when space, four-wire", int'(rts), 1);
        cfg_two_wire = 1'b1; rx_full = 1'b1;
        repeat (3) @(negedge clk);
        chk(rts == 1'b1, "R7", "rts held high, two-wire", int'(rts), 1);
        rx_full = 1'b0;

        // Receive-side corner frames, 8 data bits, even parity, one stop.
        loop_en = 1'b0;
        cfg_len = 2'b00; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop = 2'b00;
        repeat (64) @(negedge clk);
        fb = mk_frame(8'h35);
        inject(fb, 11, 8'h35, 0, 0, 0, "R1");
        fb = mk_frame(8'h35); fb[9] = ~fb[9];
        inject(fb, 11, 8'h35, 1, 0, 0, "R9");
        fb = mk_frame(8'h35); fb[10] = 1'b0;
        inject(fb, 11, 8'h35, 0, 1, 0, "R10");
        fb = mk_frame(8'h00); fb[10] = 1'b0;
        inject(fb, 11, 8'h00, 0, 1, 1, "R11");
        cfg_stop = 2'b01;
        repeat (64) @(negedge clk);
        fb = mk_frame(8'hC3); fb[11] = 1'b0;
        inject(fb, 12, 8'hC3, 0, 1, 0, "R10");
        cfg_stop = 2'b00;

        // Short low glitch is dropped at the mid-bit check (R8).
        repeat (64) @(negedge clk);
        rxd_bench = 1'b0;
        repeat (4) @(negedge clk);
        rxd_bench = 1'b1;
        cnt = 0;
        repeat (600) begin
            @(negedge clk);
            if (rx_valid) cnt++;
        end
        chk(cnt == 0, "R8", "glitch gives no character", cnt, 0);

        // A line held low reports a single break, then recovers (R13).
        rxd_bench = 1'b0;
        cnt = 0;
        repeat (32 * 36) begin
            @(negedge clk);
            if (rx_valid) begin
                cnt++;
                chk(rx_brk == 1'b1, "R11", "held low flagged as break", int'(rx_brk), 1);
            end
        end
        chk(cnt == 1, "R13", "one report for long low line", cnt, 1);
        rxd_bench = 1'b1;
        repeat (64) @(negedge clk);
        fb = mk_frame(8'h7E);
        inject(fb, 11, 8'h7E, 0, 0, 0, "R13");

        finish_run();
    end
endmodule